// File: doc/BRIEF.md
# SCSI DMA Byte Handshake Engine

This engine moves data one byte at a time between a host DMA controller and the interlocked REQ/ACK handshake of a parallel SCSI bus. It covers both sides of that handshake. As initiator it waits for the target's REQ and answers with ACK. As target it raises REQ itself and waits for the initiator's ACK. In every case it paces the host DMA request (DRQ) from the SCSI edges it sees, and it completes one host read or write strobe per byte. The data bus, its parity and bus arbitration are handled elsewhere. A single strobe from the register file picks the transfer mode and starts the engine.

The REQ and ACK inputs come from a separate clock domain. They pass through a two-flop synchroniser followed by an edge detector, and the state machine acts only on the synchronised edges. The minimum data setup times and the minimum REQ re-assertion gap are counted as whole clock cycles, set by parameters, before the engine drives its own strobe. An active end-of-process during a host strobe lets the current byte finish and then stops the engine with an end status. In initiator modes, a REQ rising edge that arrives while the bus phase does not match aborts the transfer and sets an error flag.

Top module: `scsi_dma_hs`

## Requirements
- R1: During reset and after it, drq, scsi_ack_out, scsi_req_out, scsi_dout_en, busy, end_dma, phase_err, last_byte and blk_flag are all 0.
- R2: start_mode selects the mode: 2'b00 initiator send, 2'b01 initiator receive, 2'b10 target send, 2'b11 target receive. In either initiator mode with phase_match high, a rise of scsi_req_in makes drq go high on the third rising clock edge after it. In initiator receive, scsi_din is captured onto host_rdata on that same edge.
- R3: drq goes low on the first rising edge at which dack is sampled high, and it stays low until the next byte's handshake raises it.
- R4: In initiator receive, scsi_ack_out goes high on the edge at which ior is sampled low after being high the cycle before with dack high. It goes low on the third edge after scsi_req_in falls.
- R5: In initiator send, a host write (iow high then low with dack high) latches host_wdata onto scsi_dout and sets scsi_dout_en on the completing edge. scsi_ack_out rises exactly SETUP_CYC edges later and falls on the third edge after scsi_req_in falls.
- R6: In target send, drq rises on the edge that registers start. After each host write, scsi_req_out rises SETUP_CYC edges after the write completes. The setup count runs only while the synchronised ACK is low. scsi_req_out falls, and drq rises again, on the third edge after scsi_ack_in rises.
- R7: In target receive, scsi_req_out first rises GAP_CYC edges after the edge that registers start. On the third edge after scsi_ack_in rises, scsi_din is captured onto host_rdata, scsi_req_out falls and drq rises. After the host read completes, scsi_req_out rises again GAP_CYC edges later.
- R8: In an initiator mode, a REQ rising edge seen while phase_match is low sets phase_err and returns the engine to idle (busy low) without raising drq, on the third edge after scsi_req_in rises.
- R9: eop sampled high together with dack and an active ior or iow marks the current byte as the last one. That byte completes. Then, in place of the next drq or handshake wait, the engine goes idle with end_dma set.
- R10: last_byte is set when end-of-process is seen during target send, and only then. It is cleared by the next start.
- R11: blk_flag captures block_mode on each start.
- R12: start clears end_dma, phase_err and last_byte and restarts the engine in the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle start strobe from the register file |
| start_mode | input | 2 | Transfer mode taken at start |
| block_mode | input | 1 | Block DMA flag taken at start |
| phase_match | input | 1 | High when the bus phase matches the expected phase |
| dack | input | 1 | DMA acknowledge, active high |
| ior | input | 1 | Host read strobe, active high |
| iow | input | 1 | Host write strobe, active high |
| eop | input | 1 | End of process, active high |
| host_wdata | input | DATA_W | Byte written by the host |
| host_rdata | output | DATA_W | Byte latched for the host |
| drq | output | 1 | DMA request |
| scsi_req_in | input | 1 | REQ from the bus, asynchronous |
| scsi_ack_in | input | 1 | ACK from the bus, asynchronous |
| scsi_din | input | DATA_W | Bus data in |
| scsi_req_out | output | 1 | REQ driven in target modes |
| scsi_ack_out | output | 1 | ACK driven in initiator modes |
| scsi_dout | output | DATA_W | Bus data out |
| scsi_dout_en | output | 1 | Bus data output enable |
| busy | output | 1 | Engine not idle |
| end_dma | output | 1 | Transfer ended by end-of-process |
| phase_err | output | 1 | Transfer aborted on phase mismatch |
| last_byte | output | 1 | End-of-process seen in target send |
| blk_flag | output | 1 | Captured block-mode flag |

## Verification
Every bus input change reaches the state machine three rising edges later: two synchroniser flops and one state register. The bench therefore checks each REQ- or ACK-driven result one sample before that edge and again at it. Host strobe results are due on the first edge after the strobe ends. A DACK drop of drq is due one edge after dack. Strobes that follow a wait state are due exactly SETUP_CYC or GAP_CYC edges after the event that arms the counter, and the gated case adds the two synchroniser edges. The bench drives inputs on falling edges and samples outputs on falling edges, so each check sees the value settled from exactly one rising edge.

// File: rtl/scsi_dma_hs_pkg.sv
package scsi_dma_hs_pkg;

  typedef enum logic [1:0] {
    XM_INIT_SEND = 2'b00,
    XM_INIT_RECV = 2'b01,
    XM_TGT_SEND  = 2'b10,
    XM_TGT_RECV  = 2'b11
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEER,
    ST_HOST,
    ST_SETUP,
    ST_STROBE
  } hs_state_e;

  function automatic logic mode_is_target(logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_is_recv(logic [1:0] m);
    return m[0];
  endfunction

  // wait state ahead of our own strobe: gap for target receive, setup otherwise
  function automatic int unsigned wait_cycles(logic [1:0] m, int unsigned setup_c,
                                              int unsigned gap_c);
    return (m == XM_TGT_RECV) ? gap_c : setup_c;
  endfunction

endpackage

// File: rtl/scsi_dma_hs_sync.sv
module scsi_dma_hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b0;
      else if (g == 0) chain[g] <= async_in;
      else chain[g] <= chain[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else last_q <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~last_q;
  assign fall  = ~level & last_q;
endmodule

// File: rtl/scsi_dma_hs_waitcnt.sv
module scsi_dma_hs_waitcnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = arm && run && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!arm) cnt_q <= '0;
    else if (run && !done) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/scsi_dma_hs.sv
module scsi_dma_hs
  import scsi_dma_hs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_CYC   = 4,
  parameter int GAP_CYC     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        start_mode,
  input  logic              block_mode,
  input  logic              phase_match,
  input  logic              dack,
  input  logic              ior,
  input  logic              iow,
  input  logic              eop,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              drq,
  input  logic              scsi_req_in,
  input  logic              scsi_ack_in,
  input  logic [DATA_W-1:0] scsi_din,
  output logic              scsi_req_out,
  output logic              scsi_ack_out,
  output logic [DATA_W-1:0] scsi_dout,
  output logic              scsi_dout_en,
  output logic              busy,
  output logic              end_dma,
  output logic              phase_err,
  output logic              last_byte,
  output logic              blk_flag
);
  localparam int WAIT_MAX = (SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC;
  localparam int CNT_W    = $clog2(WAIT_MAX + 1);

  hs_state_e         st_q, st_d;
  logic [1:0]        mode_q;
  logic [DATA_W-1:0] data_q;
  logic              ior_q, iow_q, eop_seen_q;

  logic req_lvl, req_rise, req_fall;
  logic ack_lvl, ack_rise, ack_fall;

  scsi_dma_hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .async_in(scsi_req_in),
    .level(req_lvl), .rise(req_rise), .fall(req_fall));

  scsi_dma_hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .async_in(scsi_ack_in),
    .level(ack_lvl), .rise(ack_rise), .fall(ack_fall));

  // named internal events
  logic mode_tgt_w, mode_recv_w;
  logic peer_go_w, pm_abort_w, host_done_w, host_eop_w;
  logic strobe_end_w, peer_idle_w, wait_done_w, stop_now_w;
  logic [CNT_W-1:0] wait_limit_w;

  assign mode_tgt_w   = mode_is_target(mode_q);
  assign mode_recv_w  = mode_is_recv(mode_q);
  assign peer_go_w    = (st_q == ST_PEER) && req_rise && phase_match;
  assign pm_abort_w   = (st_q == ST_PEER) && req_rise && !phase_match;
  assign host_done_w  = (st_q == ST_HOST) && dack &&
                        (mode_recv_w ? (ior_q && !ior) : (iow_q && !iow));
  assign host_eop_w   = (st_q == ST_HOST) && dack && eop && (ior || iow);
  assign strobe_end_w = (st_q == ST_STROBE) && (mode_tgt_w ? ack_rise : req_fall);
  assign peer_idle_w  = mode_tgt_w ? !ack_lvl : 1'b1;
  assign wait_limit_w = CNT_W'(wait_cycles(mode_q, SETUP_CYC, GAP_CYC));
  assign stop_now_w   = eop_seen_q &&
                        ((strobe_end_w && (mode_q != XM_TGT_RECV)) ||
                         (host_done_w && (mode_q == XM_TGT_RECV)));

  scsi_dma_hs_waitcnt #(.CNT_W(CNT_W)) u_wait (
    .clk(clk), .rst_n(rst_n),
    .arm(st_q == ST_SETUP), .run(peer_idle_w),
    .limit(wait_limit_w), .done(wait_done_w));

  always_comb begin
    st_d = st_q;
    if (start) begin
      if (mode_is_target(start_mode))
        st_d = mode_is_recv(start_mode) ? ST_SETUP : ST_HOST;
      else
        st_d = ST_PEER;
    end else begin
      unique case (st_q)
        ST_IDLE:  st_d = ST_IDLE;
        ST_PEER: begin
          if (pm_abort_w)     st_d = ST_IDLE;
          else if (peer_go_w) st_d = ST_HOST;
        end
        ST_HOST: begin
          if (host_done_w) begin
            if (stop_now_w)                       st_d = ST_IDLE;
            else if (mode_q == XM_INIT_RECV)      st_d = ST_STROBE;
            else                                  st_d = ST_SETUP;
          end
        end
        ST_SETUP: if (wait_done_w) st_d = ST_STROBE;
        ST_STROBE: begin
          if (strobe_end_w) begin
            if (stop_now_w)      st_d = ST_IDLE;
            else if (mode_tgt_w) st_d = ST_HOST;
            else                 st_d = ST_PEER;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ior_q <= 1'b0;
      iow_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ior_q <= ior;
      iow_q <= iow;
    end
  end

  // DMA request pacing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drq <= 1'b0;
    else if ((st_d == ST_HOST) && (start || (st_q != ST_HOST))) drq <= 1'b1;
    else if ((st_d != ST_HOST) || dack) drq <= 1'b0;
  end

  // byte latch shared by both directions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (peer_go_w && (mode_q == XM_INIT_RECV)) data_q <= scsi_din;
    else if (strobe_end_w && (mode_q == XM_TGT_RECV)) data_q <= scsi_din;
    else if (host_done_w && !mode_recv_w) data_q <= host_wdata;
  end

  // mode and status flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= XM_INIT_SEND;
      eop_seen_q <= 1'b0;
      end_dma    <= 1'b0;
      phase_err  <= 1'b0;
      last_byte  <= 1'b0;
      blk_flag   <= 1'b0;
    end else if (start) begin
      mode_q     <= start_mode;
      eop_seen_q <= 1'b0;
      end_dma    <= 1'b0;
      phase_err  <= 1'b0;
      last_byte  <= 1'b0;
      blk_flag   <= block_mode;
    end else begin
      if (pm_abort_w) phase_err <= 1'b1;
      if (host_eop_w) begin
        eop_seen_q <= 1'b1;
        if (mode_q == XM_TGT_SEND) last_byte <= 1'b1;
      end
      if (stop_now_w) begin
        end_dma    <= 1'b1;
        eop_seen_q <= 1'b0;
      end
    end
  end

  assign busy         = (st_q != ST_IDLE);
  assign scsi_ack_out = (st_q == ST_STROBE) && !mode_tgt_w;
  assign scsi_req_out = (st_q == ST_STROBE) && mode_tgt_w;
  assign scsi_dout    = data_q;
  assign scsi_dout_en = !mode_recv_w && ((st_q == ST_SETUP) || (st_q == ST_STROBE));
  assign host_rdata   = data_q;

endmodule

// File: rtl/scsi_dma_hs_chk.sv
module scsi_dma_hs_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic dack,
  input logic drq,
  input logic busy,
  input logic phase_err,
  input logic end_dma,
  input logic last_byte,
  input logic scsi_ack_out,
  input logic scsi_req_out,
  input logic mode_recv_w,
  input logic pm_abort_w,
  input logic strobe_end_w,
  input logic wait_done_w,
  input logic stop_now_w
);
  // R3: DACK removes the request on the next edge
  p_drq_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && dack && !start) |=> !drq);

  // R8: phase mismatch aborts and flags
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_abort_w && !start) |=> (phase_err && !busy));

  // R9: end-of-process stop leaves the engine idle with status
  p_eop_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_now_w && !start) |=> (end_dma && !busy && !drq));

  // R4: ACK released once the target drops REQ
  p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scsi_ack_out && strobe_end_w && !start) |=> !scsi_ack_out);

  // R6: REQ released once the initiator raises ACK
  p_req_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scsi_req_out && strobe_end_w && !start) |=> !scsi_req_out);

  // R5: sending ACK only after the setup wait ran out
  p_ack_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scsi_ack_out) && !mode_recv_w) |-> $past(wait_done_w));

  // R7: REQ only after the wait counter ran out
  p_req_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scsi_req_out) |-> $past(wait_done_w));

  // R12: start clears the status flags
  p_start_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!phase_err && !end_dma && !last_byte));
endmodule

bind scsi_dma_hs scsi_dma_hs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .dack(dack), .drq(drq),
  .busy(busy), .phase_err(phase_err), .end_dma(end_dma), .last_byte(last_byte),
  .scsi_ack_out(scsi_ack_out), .scsi_req_out(scsi_req_out),
  .mode_recv_w(mode_recv_w), .pm_abort_w(pm_abort_w),
  .strobe_end_w(strobe_end_w), .wait_done_w(wait_done_w),
  .stop_now_w(stop_now_w));

// File: tb/scsi_dma_hs_tb_top.sv
module scsi_dma_hs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETUP_N    = 3;
  localparam int GAP_N      = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, block_mode = 1'b0, phase_match = 1'b1;
  logic [1:0] start_mode = 2'b00;
  logic dack = 1'b0, ior = 1'b0, iow = 1'b0, eop = 1'b0;
  logic [7:0] host_wdata = '0, scsi_din = '0;
  logic scsi_req_in = 1'b0, scsi_ack_in = 1'b0;
  logic [7:0] host_rdata, scsi_dout;
  logic drq, scsi_req_out, scsi_ack_out, scsi_dout_en;
  logic busy, end_dma, phase_err, last_byte, blk_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_dma_hs #(.DATA_W(8), .SYNC_STAGES(2), .SETUP_CYC(SETUP_N), .GAP_CYC(GAP_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_mode(start_mode),
    .block_mode(block_mode), .phase_match(phase_match), .dack(dack), .ior(ior),
    .iow(iow), .eop(eop), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .drq(drq), .scsi_req_in(scsi_req_in), .scsi_ack_in(scsi_ack_in),
    .scsi_din(scsi_din), .scsi_req_out(scsi_req_out), .scsi_ack_out(scsi_ack_out),
    .scsi_dout(scsi_dout), .scsi_dout_en(scsi_dout_en), .busy(busy),
    .end_dma(end_dma), .phase_err(phase_err), .last_byte(last_byte),
    .blk_flag(blk_flag));

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic go(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int i, input int salt);
    return 8'((i * 29 + salt * 71 + 7) & 255);
  endfunction

  task automatic do_start(input logic [1:0] m, input logic blk);
    start = 1'b1; start_mode = m; block_mode = blk;
    go(1);
    start = 1'b0;
    chk("R11 blk_flag", blk_flag, blk);
    chk("R12 end_dma cleared", end_dma, 0);
    chk("R12 phase_err cleared", phase_err, 0);
    chk("R10 last_byte cleared", last_byte, 0);
  endtask

  // initiator receive, one byte
  task automatic ir_byte(input logic [7:0] d, input logic last);
    scsi_din = d; scsi_req_in = 1'b1;
    go(2); chk("R2 drq before sync", drq, 0);
    go(1); chk("R2 drq after req", drq, 1); chk("R2 capture", host_rdata, d);
    dack = 1'b1;
    go(1); chk("R3 drq dropped", drq, 0);
    ior = 1'b1; eop = last;
    go(1); ior = 1'b0; eop = 1'b0; chk("R4 ack before read end", scsi_ack_out, 0);
    go(1); chk("R4 ack on read end", scsi_ack_out, 1);
    dack = 1'b0; scsi_req_in = 1'b0;
    go(2); chk("R4 ack held", scsi_ack_out, 1);
    go(1); chk("R4 ack released", scsi_ack_out, 0);
    chk("R9 busy after byte", busy, !last); chk("R9 end_dma", end_dma, last);
    chk("R3 drq stays low", drq, 0);
  endtask

  // initiator send, one byte
  task automatic is_byte(input logic [7:0] d, input logic last);
    scsi_req_in = 1'b1;
    go(3); chk("R2 drq after req", drq, 1);
    dack = 1'b1; host_wdata = d;
    go(1); chk("R3 drq dropped", drq, 0);
    iow = 1'b1; eop = last;
    go(1); iow = 1'b0; eop = 1'b0;
    go(1); chk("R5 dout", scsi_dout, d); chk("R5 dout_en", scsi_dout_en, 1);
    go(SETUP_N - 1); chk("R5 ack before setup", scsi_ack_out, 0);
    go(1); chk("R5 ack after setup", scsi_ack_out, 1);
    dack = 1'b0; scsi_req_in = 1'b0;
    go(2); chk("R5 ack held", scsi_ack_out, 1);
    go(1); chk("R5 ack released", scsi_ack_out, 0);
    chk("R9 busy after byte", busy, !last); chk("R9 end_dma", end_dma, last);
    chk("R10 no last_byte as initiator", last_byte, 0);
  endtask

  // target send, one byte; hold keeps ACK high from the previous byte
  task automatic ts_byte(input logic [7:0] d, input logic last, input logic hold);
    if (!hold) scsi_ack_in = 1'b0;
    dack = 1'b1; host_wdata = d;
    go(1); chk("R3 drq dropped", drq, 0);
    iow = 1'b1; eop = last;
    go(1); iow = 1'b0; eop = 1'b0;
    go(1); chk("R6 dout", scsi_dout, d); chk("R10 last_byte", last_byte, last);
    dack = 1'b0;
    if (hold) begin
      go(SETUP_N + 2); chk("R6 req gated by ack", scsi_req_out, 0);
      scsi_ack_in = 1'b0;
      go(SETUP_N + 1); chk("R6 req before gated setup", scsi_req_out, 0);
      go(1); chk("R6 req after gated setup", scsi_req_out, 1);
    end else begin
      go(SETUP_N - 1); chk("R6 req before setup", scsi_req_out, 0);
      go(1); chk("R6 req after setup", scsi_req_out, 1);
    end
    scsi_ack_in = 1'b1;
    go(2); chk("R6 req held", scsi_req_out, 1);
    go(1); chk("R6 req released", scsi_req_out, 0);
    chk("R6 next drq", drq, !last);
    chk("R9 end_dma", end_dma, last); chk("R9 busy", busy, !last);
  endtask

  // target receive, one byte; REQ is already up on entry
  task automatic tr_byte(input logic [7:0] d, input logic last);
    scsi_din = d; scsi_ack_in = 1'b1;
    go(2); chk("R7 req held", scsi_req_out, 1);
    go(1); chk("R7 req released", scsi_req_out, 0);
    chk("R7 drq", drq, 1); chk("R7 capture", host_rdata, d);
    scsi_ack_in = 1'b0; dack = 1'b1;
    go(1); chk("R3 drq dropped", drq, 0);
    ior = 1'b1; eop = last;
    go(1); ior = 1'b0; eop = 1'b0;
    go(1); dack = 1'b0; chk("R7 req low after read", scsi_req_out, 0);
    if (last) begin
      chk("R9 end_dma", end_dma, 1); chk("R9 busy", busy, 0);
      chk("R10 no last_byte on receive", last_byte, 0);
      go(GAP_N + 1); chk("R9 no req after stop", scsi_req_out, 0);
    end else begin
      go(GAP_N - 1); chk("R7 req before gap", scsi_req_out, 0);
      go(1); chk("R7 req after gap", scsi_req_out, 1);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    go(2);
    chk("R1 drq in reset", drq, 0);
    chk("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    go(1);
    chk("R1 drq", drq, 0); chk("R1 ack", scsi_ack_out, 0); chk("R1 req", scsi_req_out, 0);
    chk("R1 dout_en", scsi_dout_en, 0); chk("R1 busy", busy, 0);
    chk("R1 flags", {end_dma, phase_err, last_byte, blk_flag}, 0);

    // initiator receive: every byte value, last one with end-of-process
    do_start(2'b01, 1'b1);
    for (int i = 0; i < 256; i++) ir_byte(8'(i), i == 255);
    scsi_req_in = 1'b1;
    go(4); chk("R9 no drq when idle", drq, 0);
    scsi_req_in = 1'b0; go(3);

    // phase mismatch
    do_start(2'b01, 1'b0);
    phase_match = 1'b0; scsi_req_in = 1'b1;
    go(2); chk("R8 phase_err before sync", phase_err, 0);
    go(1); chk("R8 phase_err", phase_err, 1); chk("R8 busy", busy, 0);
    chk("R8 no drq", drq, 0);
    scsi_req_in = 1'b0; phase_match = 1'b1; go(3);
    do_start(2'b00, 1'b0);
    chk("R12 restarted", busy, 1);

    // initiator send
    for (int i = 0; i < 64; i++) is_byte(pat(i, 1), i == 63);

    // target send, with one gated byte
    do_start(2'b10, 1'b0);
    chk("R6 drq at start", drq, 1);
    for (int i = 0; i < 32; i++) ts_byte(pat(i, 2), i == 31, i == 5);
    scsi_ack_in = 1'b0;
    chk("R10 last_byte kept", last_byte, 1);
    go(3);
    do_start(2'b11, 1'b0);
    chk("R10 last_byte cleared by start", last_byte, 0);

    // target receive
    go(GAP_N - 1); chk("R7 first req before gap", scsi_req_out, 0);
    go(1); chk("R7 first req", scsi_req_out, 1);
    for (int i = 0; i < 32; i++) tr_byte(pat(i, 3), i == 31);

    go(2);
    report();
  end
endmodule